// File: doc/BRIEF.md
# Prioritized Status LED Blink Sequencer

This block drives a single active-high status LED. Four condition inputs are ranked by priority: an external reset request, a power-sense failure, a power-good line held low, and the configuration-done flag of the programmable logic being low. The highest-ranked active condition picks one of four eight-slot on/off patterns. The LED plays that pattern in a loop. A free-running prescaler divides the system clock into slots of about one sixth of a second. When no condition is active, the device is configured and healthy, and the LED is handed to a user request line coming from the programmable logic.

A 3-bit slot counter walks through the eight slots of the selected pattern. Whenever the winning condition changes, the prescaler and the slot counter both restart, so every pattern begins at slot 0 with a full-length slot. The user request is asynchronous and passes through a two-flop synchronizer. The LED output itself is a register.

Top module: `status_led_sequencer`

## Requirements
- R1: While `rst_n` is low, `led_o` is 0. After release, the block starts in the idle condition with slot 0.
- R2: When `ext_reset_i` is 1, the LED toggles every slot. It is on in even slots (slot 0 on), which gives about 3 Hz.
- R3: When the power-fail condition wins, the LED is on in slots 0 to 4 and off in slots 5 to 7.
- R4: When the power-good-low condition wins, the LED is on in slots 0 to 3 and off in slots 4 to 7.
- R5: When the unconfigured condition wins (`cfg_done_i` = 0), the LED is on in slot 0 only.
- R6: In idle (`cfg_done_i` = 1 and no fault), `led_o` equals `user_led_i` delayed by three clock edges: two synchronizer flops plus the output register.
- R7: The priority order, highest first, is `ext_reset_i`, `pwr_fail_i`, `pgood_low_i`, then `!cfg_done_i`. While a higher condition is active, lower ones have no effect on `led_o`.
- R8: A slot lasts exactly `DIV` clock cycles. The slot index wraps from 7 to 0.
- R9: When the winning condition changes, the new pattern starts at slot 0 with a full-length slot. Its first LED value appears two edges after the edge that sampled the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_reset_i | input | 1 | External reset request flag (priority 1) |
| pwr_fail_i | input | 1 | Power-sense failure flag (priority 2) |
| pgood_low_i | input | 1 | Power-good held low flag (priority 3) |
| cfg_done_i | input | 1 | Configuration done; low means unconfigured (priority 4) |
| user_led_i | input | 1 | Asynchronous user LED request, used only in idle |
| led_o | output | 1 | Registered active-high LED drive |

## Verification
The two functions that can fall in the same cycle are a slot boundary and a change of the winning condition. When both occur, the restart must take precedence over the slot advance. The bench provokes this by switching flags on the exact cycle a slot expires, and also mid-slot. It judges the result against a reference model that counts elapsed cycles since the last change. A second overlap is several flags toggling together while a higher one holds. The model's priority pick checks that the pattern does not move.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

  localparam int unsigned SLOT_W = 3;

  typedef enum logic [2:0] {
    COND_RST   = 3'd0,
    COND_PWR   = 3'd1,
    COND_PGL   = 3'd2,
    COND_UNCFG = 3'd3,
    COND_IDLE  = 3'd4
  } cond_e;

  // Highest-priority active condition wins.
  function automatic cond_e pick_cond(input logic rst_f, input logic pwr_f,
                                      input logic pgl_f, input logic done_f);
    cond_e c;
    if (rst_f)        c = COND_RST;
    else if (pwr_f)   c = COND_PWR;
    else if (pgl_f)   c = COND_PGL;
    else if (!done_f) c = COND_UNCFG;
    else              c = COND_IDLE;
    return c;
  endfunction

  // Number of leading lit slots for the threshold-style patterns.
  function automatic logic [3:0] lit_slots(input cond_e c);
    logic [3:0] n;
    case (c)
      COND_PWR:   n = 4'd5;
      COND_PGL:   n = 4'd4;
      COND_UNCFG: n = 4'd1;
      default:    n = 4'd0;
    endcase
    return n;
  endfunction

  // Pattern value for a condition at a slot (idle handled by caller).
  function automatic logic slot_lit(input cond_e c, input logic [SLOT_W-1:0] s);
    logic v;
    if (c == COND_RST) v = ~s[0];
    else               v = ({1'b0, s} < lit_slots(c));
    return v;
  endfunction

endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int unsigned DIV = 8_333_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic slot_tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign slot_tick = at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || at_last) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R8: the divider count never leaves its range
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: a restart always begins a fresh count
  p_restart_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  generate
    if (DIV > 1) begin : g_gap
      // R8: ticks are never back to back when a slot spans several cycles
      p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !slot_tick);
    end
  endgenerate
endmodule

// File: rtl/led_slot_ctr.sv
module led_slot_ctr
  import status_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       slot_q <= '0;
    else if (restart) slot_q <= '0;
    else if (tick)    slot_q <= slot_q + 1'b1;
  end

  assign slot = slot_q;

  // R9: a condition change forces slot 0
  p_slot_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (slot_q == '0));

  // R8: a tick advances by one with wrap
  p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));

  // R8: without tick or restart the slot holds
  p_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(slot_q));
endmodule

// File: rtl/led_sync2.sv
module led_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;

  // R6: the synchronized copy trails the raw input by two edges
  p_sync_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (sync_q == $past(d_async, 2)));
endmodule

// File: rtl/status_led_sequencer.sv
module status_led_sequencer
  import status_led_pkg::*;
#(
  parameter int unsigned DIV = 8_333_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_reset_i,
  input  logic pwr_fail_i,
  input  logic pgood_low_i,
  input  logic cfg_done_i,
  input  logic user_led_i,
  output logic led_o
);
  cond_e             cond_d, cond_q;
  logic              cond_chg;
  logic              slot_tick;
  logic [SLOT_W-1:0] slot;
  logic              user_s;
  logic              pat_bit;
  logic              led_d, led_q;

  assign cond_d   = pick_cond(ext_reset_i, pwr_fail_i, pgood_low_i, cfg_done_i);
  assign cond_chg = (cond_d != cond_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= COND_IDLE;
    else        cond_q <= cond_d;
  end

  led_prescaler #(.DIV(DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (cond_chg),
    .slot_tick (slot_tick)
  );

  led_slot_ctr u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cond_chg),
    .tick    (slot_tick),
    .slot    (slot)
  );

  led_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (user_led_i),
    .d_sync  (user_s)
  );

  assign pat_bit = slot_lit(cond_q, slot);
  assign led_d   = (cond_q == COND_IDLE) ? user_s : pat_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led_o = led_q;

  // R1: output is dark during reset
  always_comb begin
    if (!rst_n) p_reset_dark_r1: assert (led_q == 1'b0 || $isunknown(led_q));
  end

  // R7: the external reset flag always wins the arbitration
  p_prio_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset_i |=> (cond_q == COND_RST));

  // R2: reset pattern lights on even slots
  p_rst_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q == COND_RST) |=> (led_o == !$past(slot[0])));

  // R5: unconfigured pattern is dark outside slot 0
  p_uncfg_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q == COND_UNCFG && slot != '0) |=> !led_o);

  // R4: power-good-low pattern is lit exactly in the first half
  p_pgl_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q == COND_PGL) |=> (led_o == !$past(slot[2])));

  // R6: idle hands the LED to the synchronized user request
  p_idle_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q == COND_IDLE) |=> (led_o == $past(user_s)));
endmodule

// File: tb/sim_status_led_sequencer.sv
module sim_status_led_sequencer;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_reset_i = 1'b0, pwr_fail_i = 1'b0, pgood_low_i = 1'b0;
  logic cfg_done_i = 1'b1, user_led_i = 1'b0;
  logic led_o;

  int total = 0, bad = 0;
  string seg_tag = "";
  bit model_on = 1'b0;

  // reference model state
  int m_cond = 4;      // 0 rst .. 4 idle
  int m_elapsed = 0;   // edges since last change
  bit m_u1 = 0, m_u2 = 0, m_led = 0;

  always #2 clk = ~clk;  // 250 MHz

  status_led_sequencer #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_reset_i(ext_reset_i), .pwr_fail_i(pwr_fail_i),
    .pgood_low_i(pgood_low_i), .cfg_done_i(cfg_done_i), .user_led_i(user_led_i),
    .led_o(led_o));

  function automatic int want_cond();
    if (ext_reset_i) return 0;
    if (pwr_fail_i)  return 1;
    if (pgood_low_i) return 2;
    if (!cfg_done_i) return 3;
    return 4;
  endfunction

  function automatic bit pattern(int c, int s, bit u);
    case (c)
      0: return (s % 2) == 0;
      1: return s <= 4;
      2: return s <= 3;
      3: return s == 0;
      default: return u;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cond = 4; m_elapsed = 0; m_u1 = 0; m_u2 = 0; m_led = 0;
    end else begin
      int nc;
      m_led = pattern(m_cond, (m_elapsed / DIV) % 8, m_u2);
      nc = want_cond();
      if (nc != m_cond) begin m_cond = nc; m_elapsed = 0; end
      else m_elapsed++;
      m_u2 = m_u1; m_u1 = user_led_i;
    end
  end

  function automatic string cond_tag(int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: led_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n)
      check(seg_tag != "" ? seg_tag : cond_tag(m_cond), led_o, m_led);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(3);
    check("R1", led_o, 1'b0);  // R1 reset state
    user_led_i = 1'b1;
    run(2);
    check("R1", led_o, 1'b0);
    user_led_i = 1'b0;
    @(negedge clk); rst_n = 1'b1; model_on = 1'b1;
    run(4);
    // R6 idle user pass-through with varied pulses
    for (int i = 0; i < 12; i++) begin
      user_led_i = (i % 3) != 0;
      run(1 + (i % 4));
    end
    user_led_i = 1'b1;
    // R5 unconfigured
    cfg_done_i = 1'b0; run(70);
    // R4 power-good low
    pgood_low_i = 1'b1; run(70);
    // R3 power fail
    pwr_fail_i = 1'b1; run(70);
    // R2 external reset
    ext_reset_i = 1'b1; run(70);
    // R7 lower flags toggled under a higher one have no effect
    seg_tag = "R7";
    for (int i = 0; i < 10; i++) begin
      pwr_fail_i = i[0]; pgood_low_i = i[1]; cfg_done_i = i[2]; user_led_i = i[0];
      run(5);
    end
    ext_reset_i = 1'b0; pwr_fail_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pgood_low_i = i[0]; cfg_done_i = i[1]; run(6);
    end
    // R8 long stretch over two full pattern wraps
    seg_tag = "R8";
    pgood_low_i = 1'b0; cfg_done_i = 1'b1; run(2 * 8 * DIV + 3);
    // R9 change right at a slot boundary and mid-slot
    seg_tag = "R9";
    pwr_fail_i = 1'b0; pgood_low_i = 1'b1; run(DIV * 3 - 1);
    pgood_low_i = 1'b0; cfg_done_i = 1'b0; run(DIV * 2);
    ext_reset_i = 1'b1; run(DIV + 1);
    ext_reset_i = 1'b0; run(DIV * 5 + 2);
    for (int k = 0; k < DIV; k++) begin
      pwr_fail_i = 1'b1; run(DIV + k);
      pwr_fail_i = 1'b0; run(DIV * 2 + k);
    end
    // back to idle
    seg_tag = "R6";
    cfg_done_i = 1'b1;
    for (int i = 0; i < 10; i++) begin user_led_i = ~user_led_i; run(2 + i); end
    run(5);
    model_on = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule